// File: doc/BRIEF.md
# Transmit Byte Streaming Engine

This block moves a run of bytes from system memory to a serial transmitter without processor involvement. Software loads a start address into the transmit pointer register. It then writes a byte total into the transmit count register, and that write launches the run. The engine reads memory one byte at a time at rising addresses and offers each byte on a valid/ready stream toward the transmitter.

When the last byte has been taken, the engine clears the pointer and count and sets an end-of-transmit status bit. If the matching enable bit is set, that status bit raises a level interrupt. Software can read the count register at any time to see how many bytes are still to go. A receive pointer register shares the same register window but has no effect on transmission.

Top module: `uart_txdma`

## Requirements
- R1: The register window uses these word indices: 0xE transmit pointer, 0xF transmit count, 0xD receive pointer, 0x8 status (bit 0 end-of-transmit, bit 1 busy) and 0x9 interrupt enable (bit 0). After reset every register reads zero, unmapped indices read zero, and busy, irq, mem_req_valid and tx_valid are low.
- R2: While idle, a write to index 0xE loads the full write data as the start address, and reading index 0xE returns it.
- R3: While idle and with a nonzero pointer, a write of a nonzero value to index 0xF starts a run of exactly that many bytes. busy is high from the next cycle until the last byte has been accepted.
- R4: Byte k of a run (k from 0) is read from address start+k, and the bytes leave on tx_data in that order.
- R5: At most one memory read is in flight. The next read is not requested before the transmitter has accepted the previous byte. A request holds its address, and an offered byte holds its value, until the partner is ready.
- R6: Reading index 0xF during a run returns the number of bytes not yet accepted by the transmitter.
- R7: In the cycle after the last byte is accepted, busy is low, the pointer and count read zero, and status bit 0 is set.
- R8: A count write does nothing if the pointer is zero, or if the low 16 bits of the write data are zero. In either case busy stays low, no memory request is made, the count reads zero and the pointer keeps its value.
- R9: While busy, writes to indices 0xE and 0xF are ignored. The run continues from its own address for its original length.
- R10: irq equals status bit 0 AND enable bit 0. Writing status with bit 0 set clears that status bit, and starting a run also clears it.
- R11: The receive pointer at index 0xD is written and read on its own, and writing it leaves the transmit pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 4 | Register write word index |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_idx | input | 4 | Register read word index |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Returned byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | Offered byte |
| busy | output | 1 | Run in progress |
| irq | output | 1 | Level interrupt on end of transmit |

## Verification
A register write takes effect at the clock edge that samples it, so busy, irq and register contents are checked at the falling edge that follows. Reads are combinational and are sampled one time step after the index is set, within that same half cycle. The memory model and the transmitter sink decide their ready signals at each falling edge and treat a handshake as happening at the next rising edge. Each byte and the remaining count are checked at that falling edge, before the handshake edge. Completion is checked at exactly one cycle after the last byte handshake, by comparing a rising-edge cycle counter with the cycle recorded at that handshake.

// File: rtl/uart_txdma_pkg.sv
package uart_txdma_pkg;

    localparam int unsigned BYTE_W    = 8;

    // word indices inside the register window
    localparam int unsigned IDX_STAT  = 8;
    localparam int unsigned IDX_IEN   = 9;
    localparam int unsigned IDX_RXPTR = 13;
    localparam int unsigned IDX_TXPTR = 14;
    localparam int unsigned IDX_TXCNT = 15;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_SEND
    } seq_state_e;

endpackage

// File: rtl/uart_txdma_seq.sv
module uart_txdma_seq
    import uart_txdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [BYTE_W-1:0] mem_rsp_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              busy_o,
    output logic              start_o,
    output logic              done_o
);

    localparam logic [IDX_W-1:0] WI_PTR  = IDX_W'(IDX_TXPTR);
    localparam logic [IDX_W-1:0] WI_CNT  = IDX_W'(IDX_TXCNT);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] data_byte;
    } seq_t;

    seq_t q, d;
    logic [CNT_W-1:0] cnt_wr;

    always_comb begin
        d       = q;
        start_o = 1'b0;
        done_o  = 1'b0;
        cnt_wr  = wr_data[CNT_W-1:0];
        unique case (q.state)
            ST_IDLE: begin
                if (wr_en) begin
                    if (wr_idx == WI_PTR) begin
                        d.ptr = wr_data[ADDR_W-1:0];
                    end else if (wr_idx == WI_CNT && cnt_wr != '0 && q.ptr != '0) begin
                        d.cnt   = cnt_wr;
                        d.state = ST_REQ;
                        start_o = 1'b1;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    d.data_byte = mem_rsp_data;
                    d.state     = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    if (q.cnt == CNT_ONE) begin
                        d.ptr   = '0;
                        d.cnt   = '0;
                        d.state = ST_IDLE;
                        done_o  = 1'b1;
                    end else begin
                        d.ptr   = q.ptr + ADDR_W'(1);
                        d.cnt   = q.cnt - CNT_ONE;
                        d.state = ST_REQ;
                    end
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_IDLE;
            q.ptr       <= '0;
            q.cnt       <= '0;
            q.data_byte <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_req_valid = (q.state == ST_REQ);
    assign mem_req_addr  = q.ptr;
    assign tx_valid      = (q.state == ST_SEND);
    assign tx_data       = q.data_byte;
    assign ptr_o         = q.ptr;
    assign cnt_o         = q.cnt;
    assign busy_o        = (q.state != ST_IDLE);

endmodule

// File: rtl/uart_txdma_regs.sv
module uart_txdma_regs
    import uart_txdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] tx_ptr,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic              busy,
    input  logic              start,
    input  logic              done,
    output logic              irq
);

    localparam logic [IDX_W-1:0] WI_STAT  = IDX_W'(IDX_STAT);
    localparam logic [IDX_W-1:0] WI_IEN   = IDX_W'(IDX_IEN);
    localparam logic [IDX_W-1:0] WI_RXPTR = IDX_W'(IDX_RXPTR);
    localparam logic [IDX_W-1:0] WI_TXPTR = IDX_W'(IDX_TXPTR);
    localparam logic [IDX_W-1:0] WI_TXCNT = IDX_W'(IDX_TXCNT);

    typedef struct packed {
        logic [ADDR_W-1:0] rx_ptr;
        logic              ien;
        logic              eot;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            if (wr_idx == WI_RXPTR) begin
                d.rx_ptr = wr_data[ADDR_W-1:0];
            end
            if (wr_idx == WI_IEN) begin
                d.ien = wr_data[0];
            end
            if (wr_idx == WI_STAT && wr_data[0]) begin
                d.eot = 1'b0;
            end
        end
        if (done) begin
            d.eot = 1'b1;
        end
        if (start) begin
            d.eot = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.rx_ptr <= '0;
            q.ien    <= 1'b0;
            q.eot    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_idx)
            WI_TXPTR: rd_data = DATA_W'(tx_ptr);
            WI_TXCNT: rd_data = DATA_W'(tx_cnt);
            WI_RXPTR: rd_data = DATA_W'(q.rx_ptr);
            WI_STAT:  rd_data = DATA_W'({busy, q.eot});
            WI_IEN:   rd_data = DATA_W'(q.ien);
            default:  rd_data = '0;
        endcase
    end

    assign irq = q.eot & q.ien;

endmodule

// File: rtl/uart_txdma.sv
module uart_txdma
    import uart_txdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [IDX_W-1:0]  reg_wr_idx,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [IDX_W-1:0]  reg_rd_idx,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [7:0]        mem_rsp_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              busy,
    output logic              irq
);

    logic [ADDR_W-1:0] tx_ptr;
    logic [CNT_W-1:0]  tx_cnt;
    logic              run_start;
    logic              run_done;

    uart_txdma_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (reg_wr_en),
        .wr_idx        (reg_wr_idx),
        .wr_data       (reg_wr_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .tx_data       (tx_data),
        .ptr_o         (tx_ptr),
        .cnt_o         (tx_cnt),
        .busy_o        (busy),
        .start_o       (run_start),
        .done_o        (run_done)
    );

    uart_txdma_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_idx  (reg_wr_idx),
        .wr_data (reg_wr_data),
        .rd_idx  (reg_rd_idx),
        .rd_data (reg_rd_data),
        .tx_ptr  (tx_ptr),
        .tx_cnt  (tx_cnt),
        .busy    (busy),
        .start   (run_start),
        .done    (run_done),
        .irq     (irq)
    );

endmodule

// File: rtl/uart_txdma_chk.sv
module uart_txdma_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              irq,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data
);

    logic              seen_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (!busy) begin
            seen_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            seen_q <= 1'b1;
            last_q <= mem_req_addr;
        end
    end

    // R5: no new read while a byte waits for the transmitter
    a_r5_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && tx_valid));

    // R5: request held until accepted
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R5: offered byte held until taken
    a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R4: accepted addresses of one run rise by one
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && seen_q) |-> (mem_req_addr == last_q + ADDR_W'(1)));

    // R3: an idle engine makes no traffic
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !tx_valid));

    // R10: a running transfer has its end status cleared
    a_r10_irq_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq);

endmodule

bind uart_txdma uart_txdma_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .irq           (irq),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data)
);

// File: tb/uart_txdma_tb.sv
`timescale 1ns/100ps
module uart_txdma_tb;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int IW = 4;

    localparam logic [IW-1:0] I_STAT = 4'h8;
    localparam logic [IW-1:0] I_IEN  = 4'h9;
    localparam logic [IW-1:0] I_RXP  = 4'hD;
    localparam logic [IW-1:0] I_TXP  = 4'hE;
    localparam logic [IW-1:0] I_TXC  = 4'hF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [IW-1:0] reg_wr_idx = '0;
    logic [DW-1:0] reg_wr_data = '0;
    logic [IW-1:0] reg_rd_idx = '0;
    logic [DW-1:0] reg_rd_data;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [7:0]    mem_rsp_data = '0;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic [7:0]    tx_data;
    logic          busy;
    logic          irq;

    always #2 clk = ~clk;

    uart_txdma u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_wr_idx    (reg_wr_idx),
        .reg_wr_data   (reg_wr_data),
        .reg_rd_idx    (reg_rd_idx),
        .reg_rd_data   (reg_rd_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .tx_data       (tx_data),
        .busy          (busy),
        .irq           (irq)
    );

    int          checks = 0;
    int          errors = 0;
    int unsigned cyc = 0;
    logic [31:0] exp_base = '0;
    int          exp_n = 0;
    int          got = 0;
    bit          watch_rem = 1'b0;
    int unsigned last_hs_cyc = 0;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [IW-1:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_idx  = idx;
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [IW-1:0] idx, output logic [31:0] data);
        reg_rd_idx = idx;
        #1;
        data = reg_rd_data;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // memory model: random accept, random 0..2 cycle response delay
    initial begin : mem_model
        bit          pend;
        int          dly;
        logic [31:0] lat;
        pend = 1'b0;
        dly  = 0;
        lat  = '0;
        forever begin
            @(negedge clk);
            if (pend && dly == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_byte(lat);
                pend          = 1'b0;
            end else begin
                mem_rsp_valid = 1'b0;
                if (pend) dly--;
            end
            mem_req_ready = ($urandom % 4) != 0;
            if (mem_req_valid && mem_req_ready) begin
                if (pend) chk("R5", "request while read in flight", 32'd1, 32'd0);
                pend = 1'b1;
                lat  = mem_req_addr;
                dly  = $urandom % 3;
            end
        end
    end

    // transmitter sink: random ready, checks each byte and remaining count
    initial begin : tx_sink
        forever begin
            @(negedge clk);
            tx_ready = ($urandom % 3) != 0;
            if (tx_valid && tx_ready) begin
                if (got >= exp_n) begin
                    chk("R3", "byte beyond run length", 32'(got + 1), 32'(exp_n));
                end else begin
                    chk("R4", "tx byte", 32'(tx_data), 32'(mem_byte(exp_base + 32'(got))));
                    if (watch_rem) chk("R6", "remaining count", reg_rd_data, 32'(exp_n - got));
                end
                got++;
                last_hs_cyc = cyc;
            end
        end
    end

    task automatic run_xfer(input logic [31:0] ptr, input int n, input bit ie, input bit poke);
        logic [31:0] v;
        int          guard;
        wr(I_IEN, 32'(ie));
        wr(I_TXP, ptr);
        exp_base   = ptr;
        exp_n      = n;
        got        = 0;
        reg_rd_idx = I_TXC;
        watch_rem  = 1'b1;
        wr(I_TXC, 32'(n));
        chk("R3", "busy after count write", 32'(busy), 32'd1);
        chk("R10", "irq cleared by start", 32'(irq), 32'd0);
        if (poke) begin
            // R9: these must not disturb the run
            wr(I_TXP, 32'h0000_0055);
            wr(I_TXC, 32'd2);
        end
        guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        watch_rem = 1'b0;
        chk("R7", "idle one cycle after last handshake", cyc, last_hs_cyc + 1);
        chk(poke ? "R9" : "R3", "bytes sent", 32'(got), 32'(n));
        rd(I_TXP, v);
        chk("R7", "pointer cleared", v, 32'd0);
        rd(I_TXC, v);
        chk("R7", "count cleared", v, 32'd0);
        rd(I_STAT, v);
        chk("R7", "status end bit set", v, 32'd1);
        chk("R10", "irq level", 32'(irq), 32'(ie));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(I_TXP, v);  chk("R1", "reset tx pointer", v, 32'd0);
        rd(I_TXC, v);  chk("R1", "reset count", v, 32'd0);
        rd(I_RXP, v);  chk("R1", "reset rx pointer", v, 32'd0);
        rd(I_STAT, v); chk("R1", "reset status", v, 32'd0);
        rd(I_IEN, v);  chk("R1", "reset enable", v, 32'd0);
        rd(4'h3, v);   chk("R1", "unmapped index", v, 32'd0);
        chk("R1", "reset outputs", {28'd0, busy, irq, mem_req_valid, tx_valid}, 32'd0);

        // R2 pointer load
        wr(I_TXP, 32'hDEAD_BEE0);
        rd(I_TXP, v);
        chk("R2", "pointer readback", v, 32'hDEAD_BEE0);

        // single-byte run with interrupt, then clear
        run_xfer(32'h0000_1000, 1, 1'b1, 1'b0);
        wr(I_STAT, 32'd1);
        chk("R10", "irq after status clear", 32'(irq), 32'd0);
        rd(I_STAT, v);
        chk("R10", "status after clear", v, 32'd0);

        // byte-carry crossing, interrupt masked, busy writes
        run_xfer(32'h0000_20FC, 9, 1'b0, 1'b1);
        wr(I_IEN, 32'd1);
        chk("R10", "irq once enabled", 32'(irq), 32'd1);

        // R8 zero pointer
        wr(I_TXC, 32'd5);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8", "no run with zero pointer", {30'd0, busy, mem_req_valid}, 32'd0);
        end
        rd(I_TXC, v);
        chk("R8", "count after zero-pointer write", v, 32'd0);

        // R8 zero count and truncated count
        wr(I_TXP, 32'h0000_0300);
        wr(I_TXC, 32'd0);
        @(negedge clk);
        chk("R8", "no run with zero count", 32'(busy), 32'd0);
        wr(I_TXC, 32'h0001_0000);
        @(negedge clk);
        chk("R8", "no run with zero low count bits", {30'd0, busy, mem_req_valid}, 32'd0);
        rd(I_TXP, v);
        chk("R8", "pointer kept", v, 32'h0000_0300);

        // R11 receive pointer independence
        wr(I_RXP, 32'hABCD_0001);
        rd(I_TXP, v);
        chk("R11", "tx pointer unchanged", v, 32'h0000_0300);
        rd(I_RXP, v);
        chk("R11", "rx pointer readback", v, 32'hABCD_0001);

        // constrained random runs
        for (int k = 0; k < 10; k++) begin
            logic [31:0] p;
            int          n;
            bit          pk;
            p  = $urandom | 32'd1;
            n  = 1 + ($urandom % 12);
            pk = (n >= 6) && ($urandom % 2 == 1);
            run_xfer(p, n, 1'($urandom % 2), pk);
            if ($urandom % 2 == 1) begin
                wr(I_STAT, 32'd1);
                rd(I_STAT, v);
                chk("R10", "status cleared by write", v, 32'd0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule